// File: doc/BRIEF.md
# Aligned Range Region Splitter

This block covers a contiguous range of physical pages with a sequence of naturally aligned, power-of-two sized regions, and emits one base/mask register pair per region into a bank of variable-range cache-type registers. A command gives a start page number, a page count, a memory type and the index of the first register to fill. The engine then walks the range. On each step it picks the largest region that fits both the remaining count and the alignment of the current start page. It streams the encoded pair out, then advances. A second command form disables a single register by writing an all-zero pair.

The command side uses a plain start pulse with busy and done. The register write side is a valid/ready stream. A pair is transferred on every rising edge where `wr_valid` and `wr_ready` are both high, so with `wr_ready` held high one pair leaves per cycle. While `wr_valid` is high and `wr_ready` is low, the pair on the stream is held unchanged until it is taken. The producer never withdraws a pair it has offered. Two registers at the top of the bank are never filled by range commands. When the engine finishes it reports the index of the next free register.

Top module: `region_splitter`

## Requirements
- R1: After reset, `busy`, `done` and `wr_valid` are 0 and `next_reg` is 0.
- R2: Each region has size 2^e pages. e is the smaller of two values: the number of trailing zero bits of the current start page (24 when the start page is 0), and the bit position of the most significant set bit of the remaining count. The region base is therefore aligned to its size.
- R3: The base word is 36 bits. Bits 35:12 hold the region's start page and bits 7:0 hold the memory type. All other bits are 0.
- R4: The mask word is 36 bits. Bits 35:12 hold the 24-bit two's-complement negation of the region size in pages. Bit 11 is set as the valid flag and bits 10:0 are otherwise 0.
- R5: After each accepted pair, the start page advances by the region size and the count shrinks by the same amount. Register indexes run consecutively from `first_reg`. The command ends when the count reaches 0, and `next_reg` then equals `first_reg` plus the number of pairs written.
- R6: With NUM_REGS = 8 and two reserved registers, range commands never write index 6 or above. A command stops once the index reaches 6 even when pages remain, and `next_reg` is then 6.
- R7: A range command with a count of 0, or with `first_reg` of 6 or more, writes no pair and reports `next_reg` equal to `first_reg`.
- R8: A command with `disable_op` = 1 writes exactly one pair, at index `first_reg`, with base and mask both 0. `next_reg` is then equal to `first_reg`.
- R9: While `wr_valid` is 1 and `wr_ready` is 0, on the next cycle `wr_valid` stays 1 and `wr_idx`, `wr_base` and `wr_mask` are unchanged.
- R10: `done` is high for exactly one cycle per command and never together with `busy`. A `start` pulse seen while `busy` or `done` is high is ignored and does not change the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command pulse, taken only when idle |
| disable_op | input | 1 | With start: disable one register instead of covering a range |
| first_reg | input | 4 | First register index to fill |
| start_page | input | 24 | First page number of the range |
| page_count | input | 24 | Number of pages in the range |
| mem_type | input | 8 | Memory type placed in the base word |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| next_reg | output | 4 | Index of the next free register after the last command |
| wr_valid | output | 1 | A register pair is offered |
| wr_ready | input | 1 | The bank accepts the offered pair |
| wr_idx | output | 4 | Register index of the offered pair |
| wr_base | output | 36 | Encoded base word |
| wr_mask | output | 36 | Encoded mask word |

## Verification
A wrong size choice shows on the first pair where start alignment and count disagree. The mask of that pair has the wrong number of leading ones, and every later base is shifted, so a single faulty step corrupts the rest of the sequence within a cycle or two. A wrong index counter or register limit shows as an extra or a missing pair, and as a wrong `next_reg` on the `done` cycle. A state machine that loses track of back-pressure shows as a pair that changes or disappears while `wr_ready` is low, or as a pair that is skipped.

// File: rtl/region_splitter_pkg.sv
package region_splitter_pkg;
  localparam int PA_W       = 36;
  localparam int PAGE_SHIFT = 12;
  localparam int PAGE_W     = PA_W - PAGE_SHIFT;
  localparam int TYPE_W     = 8;
  localparam int VALID_BIT  = 11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } split_state_e;
endpackage

// File: rtl/region_size_unit.sv
module region_size_unit #(
  parameter int PAGE_W = 24,
  parameter int EXP_W  = $clog2(PAGE_W + 1)
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] count,
  output logic [EXP_W-1:0]  size_exp,
  output logic [PAGE_W-1:0] size_pages
);
  logic [EXP_W-1:0] align_exp;
  logic [EXP_W-1:0] fit_exp;

  // lowest set bit of the page number; an all-zero page gives PAGE_W
  always_comb begin
    align_exp = EXP_W'(PAGE_W);
    for (int i = PAGE_W - 1; i >= 0; i--) begin
      if (page[i]) align_exp = EXP_W'(i);
    end
  end

  // highest set bit of the remaining count
  always_comb begin
    fit_exp = '0;
    for (int i = 0; i < PAGE_W; i++) begin
      if (count[i]) fit_exp = EXP_W'(i);
    end
  end

  assign size_exp   = (align_exp < fit_exp) ? align_exp : fit_exp;
  assign size_pages = PAGE_W'(1) << size_exp;
endmodule

// File: rtl/region_encoder.sv
module region_encoder #(
  parameter int PA_W       = 36,
  parameter int PAGE_SHIFT = 12,
  parameter int TYPE_W     = 8,
  parameter int VALID_BIT  = 11,
  localparam int PAGE_W    = PA_W - PAGE_SHIFT
) (
  input  logic              blank,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] size_pages,
  input  logic [TYPE_W-1:0] mem_type,
  output logic [PA_W-1:0]   base_word,
  output logic [PA_W-1:0]   mask_word
);
  logic [PAGE_W-1:0] neg_size;
  logic [PA_W-1:0]   base_raw;
  logic [PA_W-1:0]   mask_raw;

  assign neg_size = PAGE_W'(0) - size_pages;

  always_comb begin
    base_raw = {page, {PAGE_SHIFT{1'b0}}};
    base_raw[TYPE_W-1:0] = mem_type;
    mask_raw = {neg_size, {PAGE_SHIFT{1'b0}}};
    mask_raw[VALID_BIT] = 1'b1;
  end

  assign base_word = blank ? '0 : base_raw;
  assign mask_word = blank ? '0 : mask_raw;
endmodule

// File: rtl/region_splitter.sv
module region_splitter
  import region_splitter_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int RESERVED  = 2,
  localparam int IDX_W    = $clog2(NUM_REGS) + 1,
  localparam int LIMIT    = NUM_REGS - RESERVED,
  localparam int EXP_W    = $clog2(PAGE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              disable_op,
  input  logic [IDX_W-1:0]  first_reg,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [PAGE_W-1:0] page_count,
  input  logic [TYPE_W-1:0] mem_type,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  next_reg,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [PA_W-1:0]   wr_base,
  output logic [PA_W-1:0]   wr_mask
);
  split_state_e      state_q;
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] remain_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TYPE_W-1:0] type_q;
  logic              blank_q;
  logic [IDX_W-1:0]  next_q;

  logic [EXP_W-1:0]  step_exp;
  logic [PAGE_W-1:0] step_size;
  logic [PAGE_W-1:0] remain_after;
  logic [IDX_W-1:0]  idx_after;
  logic              fire;
  logic              cmd_empty;

  region_size_unit #(.PAGE_W(PAGE_W)) u_size (
    .page       (page_q),
    .count      (remain_q),
    .size_exp   (step_exp),
    .size_pages (step_size)
  );

  region_encoder #(
    .PA_W       (PA_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .TYPE_W     (TYPE_W),
    .VALID_BIT  (VALID_BIT)
  ) u_enc (
    .blank      (blank_q),
    .page       (page_q),
    .size_pages (step_size),
    .mem_type   (type_q),
    .base_word  (wr_base),
    .mask_word  (wr_mask)
  );

  assign fire         = (state_q == ST_RUN) && wr_ready;
  assign remain_after = remain_q - step_size;
  assign idx_after    = idx_q + IDX_W'(1);
  assign cmd_empty    = (page_count == '0) || (first_reg >= IDX_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      page_q   <= '0;
      remain_q <= '0;
      idx_q    <= '0;
      type_q   <= '0;
      blank_q  <= 1'b0;
      next_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            page_q   <= start_page;
            remain_q <= page_count;
            idx_q    <= first_reg;
            type_q   <= mem_type;
            blank_q  <= disable_op;
            next_q   <= first_reg;
            if (disable_op || !cmd_empty) state_q <= ST_RUN;
            else                          state_q <= ST_FIN;
          end
        end
        ST_RUN: begin
          if (fire) begin
            if (blank_q) begin
              state_q <= ST_FIN;
            end else begin
              page_q   <= page_q + step_size;
              remain_q <= remain_after;
              idx_q    <= idx_after;
              if (remain_after == '0 || idx_after >= IDX_W'(LIMIT)) begin
                next_q  <= idx_after;
                state_q <= ST_FIN;
              end
            end
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == ST_RUN);
  assign done     = (state_q == ST_FIN);
  assign wr_valid = (state_q == ST_RUN);
  assign wr_idx   = idx_q;
  assign next_reg = next_q;

  logic unused_exp;
  assign unused_exp = ^step_exp;
endmodule

// File: rtl/region_splitter_checker.sv
module region_splitter_checker #(
  parameter int IDX_W = 4,
  parameter int LIMIT = 6,
  parameter int PA_W  = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [IDX_W-1:0] wr_idx,
  input logic [PA_W-1:0]  wr_base,
  input logic [PA_W-1:0]  wr_mask
);
  AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_idx) && $stable(wr_base) && $stable(wr_mask))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)); // R10

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_base[PA_W-1:12] & ~wr_mask[PA_W-1:12]) == '0)); // R2

  AST_RANGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_mask != '0) |-> (wr_idx < IDX_W'(LIMIT))); // R6

  AST_MASK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_mask[10:0] == '0)); // R4
endmodule

bind region_splitter region_splitter_checker #(
  .IDX_W (IDX_W),
  .LIMIT (LIMIT),
  .PA_W  (region_splitter_pkg::PA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_idx   (wr_idx),
  .wr_base  (wr_base),
  .wr_mask  (wr_mask)
);

// File: tb/region_splitter_tb.sv
module region_splitter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, disable_op, wr_ready;
  logic [3:0]  first_reg;
  logic [23:0] start_page, page_count;
  logic [7:0]  mem_type;
  logic        busy, done, wr_valid;
  logic [3:0]  next_reg, wr_idx;
  logic [35:0] wr_base, wr_mask;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #5 clk = ~clk;

  region_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .disable_op(disable_op),
    .first_reg(first_reg), .start_page(start_page), .page_count(page_count),
    .mem_type(mem_type), .busy(busy), .done(done), .next_reg(next_reg),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_mask(wr_mask)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // stimulus table: first_reg, start_page, page_count, type, expected next_reg, expected pair count
  localparam int NV = 8;
  localparam logic [3:0]  V_FIRST [NV] = '{4'd0, 4'd0, 4'd2, 4'd1, 4'd6, 4'd7, 4'd3, 4'd0};
  localparam logic [23:0] V_PAGE  [NV] = '{24'h0, 24'h3, 24'h1, 24'h40, 24'h4, 24'h0, 24'h100, 24'h0};
  localparam logic [23:0] V_COUNT [NV] = '{24'h100, 24'h5, 24'h7F, 24'h0, 24'h4, 24'h8, 24'h100, 24'hFFFFFF};
  localparam logic [7:0]  V_TYPE  [NV] = '{8'h06, 8'h01, 8'h04, 8'h06, 8'h05, 8'h06, 8'h06, 8'h00};
  localparam logic [3:0]  V_NEXT  [NV] = '{4'd1, 4'd2, 4'd6, 4'd1, 4'd6, 4'd7, 4'd4, 4'd6};
  localparam int          V_NW    [NV] = '{1, 2, 4, 0, 0, 0, 1, 6};

  task automatic run(input logic [3:0] f, input logic [23:0] pg, input logic [23:0] cn,
                     input logic [7:0] ty, input bit dis, input bit slow, input bit poke,
                     input logic [3:0] x_next, input int x_nw);
    logic [3:0]  e_idx  [16];
    logic [35:0] e_base [16];
    logic [35:0] e_mask [16];
    int ne = 0;
    logic [23:0] p = pg, c = cn;
    logic [3:0]  r = f;
    int got = 0, cy = 0;
    bit hold = 0;
    logic [3:0]  h_idx;
    logic [35:0] h_base, h_mask;
    bit seen_done = 0;
    // reference per R2..R8
    if (dis) begin
      e_idx[0] = f; e_base[0] = '0; e_mask[0] = '0; ne = 1;
    end else if (c != 0 && r < 4'd6) begin
      while (c != 0) begin
        int tz = 24, ms = 0, e;
        logic [23:0] sz, ng;
        for (int i = 23; i >= 0; i--) if (p[i]) tz = i;
        for (int i = 0; i < 24; i++) if (c[i]) ms = i;
        e = (tz < ms) ? tz : ms;
        sz = 24'd1 << e;
        ng = 24'd0 - sz;
        e_idx[ne] = r;
        e_base[ne] = {p, 4'h0, ty};
        e_mask[ne] = {ng, 1'b1, 11'h0};
        ne++;
        p = p + sz; c = c - sz; r = r + 4'd1;
        if (r >= 4'd6) break;
      end
    end
    check(ne == x_nw, "R5", "reference pair count", 36'(ne), 36'(x_nw));
    @(negedge clk);
    start = 1'b1; disable_op = dis; first_reg = f; start_page = pg;
    page_count = cn; mem_type = ty;
    @(negedge clk);
    start = 1'b0;
    while (!seen_done && cy < 200) begin
      if (poke && cy == 1) begin
        start = 1'b1; first_reg = 4'd0; page_count = 24'h1; disable_op = 1'b0;
      end else if (poke && cy == 2) begin
        start = 1'b0;
      end
      wr_ready = slow ? cy[0] : 1'b1;
      if (hold) begin
        check(wr_valid && wr_idx == h_idx && wr_base == h_base && wr_mask == h_mask,
              "R9", "pair held under back-pressure", wr_base, h_base);
      end
      hold = 0;
      if (done) begin
        seen_done = 1;
        check(!busy, "R10", "busy low with done", 36'(busy), 36'd0);
        check(next_reg == x_next, "R5/R6/R7", "next_reg", 36'(next_reg), 36'(x_next));
        check(got == ne, "R5", "pairs written", 36'(got), 36'(ne));
      end else if (wr_valid && wr_ready) begin
        if (got < ne) begin
          check(wr_idx == e_idx[got], "R5", "wr_idx", 36'(wr_idx), 36'(e_idx[got]));
          check(wr_base == e_base[got], dis ? "R8" : "R3", "wr_base", wr_base, e_base[got]);
          check(wr_mask == e_mask[got], dis ? "R8" : "R4", "wr_mask", wr_mask, e_mask[got]);
        end else begin
          check(1'b0, "R6", "extra pair", 36'(wr_idx), 36'hF);
        end
        got++;
      end else if (wr_valid) begin
        hold = 1; h_idx = wr_idx; h_base = wr_base; h_mask = wr_mask;
      end
      @(negedge clk);
      cy++;
    end
    check(seen_done, "R10", "done seen", 36'(seen_done), 36'd1);
    check(!done, "R10", "done lasts one cycle", 36'(done), 36'd0);
    wr_ready = 1'b1;
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; disable_op = 1'b0; wr_ready = 1'b1;
    first_reg = '0; start_page = '0; page_count = '0; mem_type = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !wr_valid, "R1", "control outputs idle",
          {33'd0, busy, done, wr_valid}, 36'd0);
    check(next_reg == 4'd0, "R1", "next_reg after reset", 36'(next_reg), 36'd0);

    // table walk: R2..R7
    for (int v = 0; v < NV; v++) begin
      run(V_FIRST[v], V_PAGE[v], V_COUNT[v], V_TYPE[v], 1'b0, 1'b0, 1'b0, V_NEXT[v], V_NW[v]);
    end

    // R8 disable one register
    run(4'd5, 24'h123, 24'h10, 8'h06, 1'b1, 1'b0, 1'b0, 4'd5, 1);
    run(4'd7, 24'h0, 24'h0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd7, 1);

    // R9 back-pressure with alternating ready
    run(4'd0, 24'h3, 24'h5, 8'h01, 1'b0, 1'b1, 1'b0, 4'd2, 2);
    run(4'd1, 24'h1, 24'h7F, 8'h05, 1'b0, 1'b1, 1'b0, 4'd6, 5);

    // R10 start while busy is ignored
    run(4'd2, 24'h1, 24'h7F, 8'h04, 1'b0, 1'b1, 1'b1, 4'd6, 4);

    // R6 range ending exactly at the limit
    run(4'd4, 24'h8, 24'h18, 8'h06, 1'b0, 1'b0, 1'b0, 4'd6, 2);

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule